// File: doc/BRIEF.md
# Repeating Block Copy and Search Engine

This engine walks a region of byte memory under the control of three pointers: a source address, a destination address and a byte count. A start pulse loads the pointers together with the operating options. In copy mode each iteration reads the byte at the source address and writes it to the destination address. In search mode each iteration reads the byte at the source address and compares it with a reference byte, and it never writes. After each iteration both addresses move by one and the count drops by one. The addresses move up or down, as a direction input selects.

A single-step run performs exactly one iteration. A repeating run keeps iterating until the count reaches zero. In search mode a repeating run also stops at the first matching byte. Two flags let a caller tell exhaustion apart from a hit. The count flag is low once the count has reached zero. The match flag is high when the last compared byte equalled the reference. When a run ends, a one-cycle done pulse appears. The final pointers and flags then stay visible until the next start.

The memory port is a plain synchronous single port with one cycle of read latency. Every iteration takes a fixed number of clocks, set by a parameter that defaults to 21.

Top module: `blk_move_engine`

## Requirements
- R1: After reset `busy`, `done`, `flag_cnt_nz`, `flag_match`, `src_out`, `dst_out` and `cnt_out` are all zero.
- R2: A copy iteration writes the byte read from `src_out` to `dst_out`. With `dir_down`=0 it increments both addresses and decrements the count.
- R3: With `dir_down`=1 both addresses decrement by one per iteration.
- R4: A repeating copy (`rep_en`=1, `op_search`=0) iterates until the count reaches zero, and every byte of the region is moved.
- R5: Every iteration lasts exactly STEP_CYCLES (21) clocks. `done` is high in the clock cycle N*21 edges after the start edge for N iterations.
- R6: After each iteration `flag_cnt_nz` is 0 if the count has just reached zero and 1 otherwise.
- R7: A search iteration (`op_search`=1) sets `flag_match` to 1 when the byte at the source address equals `ref_byte` and to 0 otherwise. It writes no memory and leaves `dst_out` unchanged.
- R8: A repeating search stops after the first match or when the count reaches zero, whichever comes first. `src_out` is then one past the last compared byte.
- R9: A start with a count of zero runs as if the count were 65536, so the first iteration leaves 0xFFFF.
- R10: `done` is high for one cycle. The final pointers stay unchanged until the next accepted start.
- R11: A start that arrives while `busy` is high is ignored.
- R12: A copy iteration leaves `flag_match` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| op_search | input | 1 | 1 = search, 0 = copy |
| rep_en | input | 1 | 1 = repeat until finished, 0 = single iteration |
| dir_down | input | 1 | 1 = addresses decrement |
| src_in | input | AW | Initial source address |
| dst_in | input | AW | Initial destination address |
| cnt_in | input | AW | Initial byte count (0 means 65536) |
| ref_byte | input | DW | Byte searched for |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after `mem_rd` |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| src_out | output | AW | Current source address |
| dst_out | output | AW | Current destination address |
| cnt_out | output | AW | Current count |
| flag_cnt_nz | output | 1 | Count non-zero after the last iteration |
| flag_match | output | 1 | Last compared byte equalled the reference |

## Verification
The copy function is tried in three forms. A single upward step and a single downward step separate the two directions. A four-byte repeating copy checks both termination at zero and the exact 21-clock iteration period. Search is run in three ways: with a match in the middle of the region, which shows an early stop with the count still non-zero; with no match at all, which shows exhaustion with both flags low; and with a starting count of zero, which shows the 65536 wrap. A start pulse injected during a run, and a copy step issued after a hit, confirm that neither disturbs state they must leave alone.

// File: rtl/blk_pkg.sv
package blk_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } blk_state_e;

  typedef struct packed {
    logic search;
    logic rep;
    logic down;
  } blk_cfg_t;
endpackage

// File: rtl/blk_step_timer.sv
module blk_step_timer #(
  parameter int STEP_CYCLES = 21,
  localparam int TW = (STEP_CYCLES > 2) ? $clog2(STEP_CYCLES) : 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          run,
  output logic [TW-1:0] phase,
  output logic          last
);
  localparam logic [TW-1:0] PH_LAST = TW'(STEP_CYCLES - 1);

  logic [TW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      phase_q <= '0;
    end else if (run) begin
      phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
    end
  end

  assign phase = phase_q;
  assign last  = (phase_q == PH_LAST);

  p_phase_bound_r5: assert property (@(posedge clk) disable iff (rst)
    phase_q <= PH_LAST) else $error("phase beyond iteration length");
endmodule

// File: rtl/blk_ptr_regs.sv
module blk_ptr_regs #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [AW-1:0] cnt_i,
  input  logic          step,
  input  logic          down,
  input  logic          move_dst,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [AW-1:0] cnt_q,
  output logic [AW-1:0] cnt_dec
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] src_nx, dst_nx;

  assign src_nx  = down ? src_q - ONE : src_q + ONE;
  assign dst_nx  = down ? dst_q - ONE : dst_q + ONE;
  assign cnt_dec = cnt_q - ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      src_q <= src_i;
      dst_q <= dst_i;
      cnt_q <= cnt_i;
    end else if (step) begin
      src_q <= src_nx;
      cnt_q <= cnt_dec;
      if (move_dst) dst_q <= dst_nx;
    end
  end
endmodule

// File: rtl/blk_flag_unit.sv
module blk_flag_unit #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          search,
  input  logic [DW-1:0] rdata,
  input  logic [DW-1:0] ref_val,
  input  logic [AW-1:0] cnt_after,
  output logic          pv_q,
  output logic          z_q
);
  logic hit;
  assign hit = (rdata == ref_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      pv_q <= 1'b0;
      z_q  <= 1'b0;
    end else if (step) begin
      pv_q <= (cnt_after != '0);
      if (search) z_q <= hit;
    end
  end

  p_z_copy_keep_r12: assert property (@(posedge clk) disable iff (rst)
    step && !search |=> $stable(z_q)) else $error("copy altered match flag");
endmodule

// File: rtl/blk_move_engine.sv
module blk_move_engine
  import blk_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int STEP_CYCLES = 21
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op_search,
  input  logic          rep_en,
  input  logic          dir_down,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [AW-1:0] cnt_in,
  input  logic [DW-1:0] ref_byte,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] src_out,
  output logic [AW-1:0] dst_out,
  output logic [AW-1:0] cnt_out,
  output logic          flag_cnt_nz,
  output logic          flag_match
);
  localparam int TW = (STEP_CYCLES > 2) ? $clog2(STEP_CYCLES) : 2;
  localparam logic [TW-1:0] PH_READ = TW'(0);
  localparam logic [TW-1:0] PH_XFER = TW'(1);

  blk_state_e    state_q;
  blk_cfg_t      cfg_q;
  logic [DW-1:0] ref_q;
  logic          done_q;
  logic [TW-1:0] phase;
  logic          last_ph;
  logic          running, accept, xfer, finish, stop_cond;
  logic [AW-1:0] cnt_dec;

  assign running = (state_q == ST_RUN);
  assign accept  = start && (state_q == ST_IDLE);
  assign xfer    = running && (phase == PH_XFER);

  blk_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .run   (running),
    .phase (phase),
    .last  (last_ph)
  );

  blk_ptr_regs #(.AW(AW)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .src_i    (src_in),
    .dst_i    (dst_in),
    .cnt_i    (cnt_in),
    .step     (xfer),
    .down     (cfg_q.down),
    .move_dst (!cfg_q.search),
    .src_q    (src_out),
    .dst_q    (dst_out),
    .cnt_q    (cnt_out),
    .cnt_dec  (cnt_dec)
  );

  blk_flag_unit #(.AW(AW), .DW(DW)) u_flag (
    .clk       (clk),
    .rst       (rst),
    .step      (xfer),
    .search    (cfg_q.search),
    .rdata     (mem_rdata),
    .ref_val   (ref_q),
    .cnt_after (cnt_dec),
    .pv_q      (flag_cnt_nz),
    .z_q       (flag_match)
  );

  // Pointers and flags already hold this iteration's result at the last phase.
  assign stop_cond = !cfg_q.rep || (cnt_out == '0) || (cfg_q.search && flag_match);
  assign finish    = running && last_ph && stop_cond;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      ref_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept) begin
        state_q <= ST_RUN;
        cfg_q   <= '{search: op_search, rep: rep_en, down: dir_down};
        ref_q   <= ref_byte;
      end else if (finish) begin
        state_q <= ST_IDLE;
      end
    end
  end

  assign mem_rd    = running && (phase == PH_READ);
  assign mem_wr    = xfer && !cfg_q.search;
  assign mem_addr  = mem_wr ? dst_out : src_out;
  assign mem_wdata = mem_rdata;
  assign busy      = running;
  assign done      = done_q;

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle");

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !busy && !start |=> $stable(src_out) && $stable(dst_out) && $stable(cnt_out))
    else $error("pointers moved while idle");

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
    xfer |=> cnt_out == $past(cnt_out) - AW'(1)) else $error("count not decremented");

  p_pv_final_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> flag_cnt_nz == (cnt_out != '0)) else $error("count flag mismatch");

  p_search_dst_r7: assert property (@(posedge clk) disable iff (rst)
    busy && cfg_q.search |=> $stable(dst_out)) else $error("search moved destination");

  p_end_phase_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(last_ph)) else $error("run ended mid iteration");
endmodule

// File: tb/blk_move_engine_tb.sv
module blk_move_engine_tb;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int SC = 21;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0, op_search = 1'b0, rep_en = 1'b0, dir_down = 1'b0;
  logic [AW-1:0] src_in = '0, dst_in = '0, cnt_in = '0;
  logic [DW-1:0] ref_byte = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          busy, done, flag_cnt_nz, flag_match;
  logic [AW-1:0] src_out, dst_out, cnt_out;

  logic [DW-1:0] mem [256];
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
  end

  blk_move_engine #(.AW(AW), .DW(DW), .STEP_CYCLES(SC)) u_dut (
    .clk(clk), .rst(rst), .start(start), .op_search(op_search), .rep_en(rep_en),
    .dir_down(dir_down), .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in),
    .ref_byte(ref_byte), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out),
    .flag_cnt_nz(flag_cnt_nz), .flag_match(flag_match)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Start a run; returns the number of edges from the start edge to done.
  // If inj_at > 0, a stray start with other values is pulsed at that cycle.
  task automatic go(input logic srch, input logic rep, input logic dn,
                    input logic [AW-1:0] s, input logic [AW-1:0] d,
                    input logic [AW-1:0] c, input logic [DW-1:0] r,
                    input int inj_at, output int cyc);
    @(negedge clk);
    op_search = srch; rep_en = rep; dir_down = dn;
    src_in = s; dst_in = d; cnt_in = c; ref_byte = r;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    cyc = 0;
    while (cyc < 5000) begin
      @(posedge clk); #1;
      cyc++;
      start = 1'b0;
      if (done) break;
      if (inj_at > 0 && cyc == inj_at) begin
        src_in = 16'h0070; dst_in = 16'h00D0; cnt_in = 16'd1; op_search = 1'b0;
        start = 1'b1;
      end
    end
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 src", src_out, 0);
    chk("R1 dst", dst_out, 0);
    chk("R1 cnt", cnt_out, 0);
    chk("R1 flags", {flag_cnt_nz, flag_match}, 0);
  endtask

  task automatic t_copy_up_single();
    int cyc;
    go(0, 0, 0, 16'h0010, 16'h0080, 16'd5, 8'h00, 0, cyc);
    chk("R2 data", mem[8'h80], 8'h10);
    chk("R2 src", src_out, 16'h0011);
    chk("R2 dst", dst_out, 16'h0081);
    chk("R2 cnt", cnt_out, 16'd4);
    chk("R6 nz", flag_cnt_nz, 1);
    chk("R5 single", cyc, SC);
  endtask

  task automatic t_copy_down_single();
    int cyc;
    go(0, 0, 1, 16'h0020, 16'h0090, 16'd1, 8'h00, 0, cyc);
    chk("R3 data", mem[8'h90], 8'h20);
    chk("R3 src", src_out, 16'h001F);
    chk("R3 dst", dst_out, 16'h008F);
    chk("R6 zero", flag_cnt_nz, 0);
  endtask

  task automatic t_copy_repeat();
    int cyc;
    go(0, 1, 0, 16'h0030, 16'h00A0, 16'd4, 8'h00, 0, cyc);
    chk("R5 repeat time", cyc, 4 * SC);
    for (int i = 0; i < 4; i++) chk("R4 data", mem[8'hA0 + i], 8'h30 + i);
    chk("R4 cnt", cnt_out, 0);
    chk("R4 src", src_out, 16'h0034);
    chk("R4 dst", dst_out, 16'h00A4);
    chk("R6 end", flag_cnt_nz, 0);
    @(posedge clk); #1;
    chk("R10 pulse", done, 0);
    repeat (5) @(posedge clk);
    #1;
    chk("R10 hold", {src_out, dst_out, cnt_out}, {16'h0034, 16'h00A4, 16'h0000});
  endtask

  task automatic t_search_hit();
    int cyc;
    go(1, 1, 0, 16'h0040, 16'h00E0, 16'd10, 8'h45, 0, cyc);
    chk("R8 time", cyc, 6 * SC);
    chk("R8 src", src_out, 16'h0046);
    chk("R8 cnt", cnt_out, 16'd4);
    chk("R7 match", flag_match, 1);
    chk("R6 hit nz", flag_cnt_nz, 1);
    chk("R7 dst", dst_out, 16'h00E0);
    chk("R7 nowrite", mem[8'hE0], 8'hE0);
  endtask

  task automatic t_copy_keeps_z();
    int cyc;
    go(0, 0, 0, 16'h0011, 16'h0081, 16'd2, 8'h00, 0, cyc);
    chk("R12 z kept", flag_match, 1);
    chk("R2 data2", mem[8'h81], 8'h11);
  endtask

  task automatic t_search_miss();
    int cyc;
    go(1, 1, 0, 16'h0050, 16'h00E8, 16'd3, 8'h07, 0, cyc);
    chk("R8 miss time", cyc, 3 * SC);
    chk("R8 miss src", src_out, 16'h0053);
    chk("R8 miss cnt", cnt_out, 0);
    chk("R7 nomatch", flag_match, 0);
    chk("R6 miss", flag_cnt_nz, 0);
  endtask

  task automatic t_search_wrap();
    int cyc;
    go(1, 1, 0, 16'h0060, 16'h00E8, 16'd0, 8'h62, 0, cyc);
    chk("R9 cnt", cnt_out, 16'hFFFD);
    chk("R9 src", src_out, 16'h0063);
    chk("R9 nz", flag_cnt_nz, 1);
    chk("R9 match", flag_match, 1);
  endtask

  task automatic t_start_ignored();
    int cyc;
    go(0, 1, 0, 16'h0000, 16'h00C0, 16'd3, 8'h00, 10, cyc);
    chk("R11 time", cyc, 3 * SC);
    chk("R11 src", src_out, 16'h0003);
    chk("R11 dst", dst_out, 16'h00C3);
    for (int i = 0; i < 3; i++) chk("R11 data", mem[8'hC0 + i], i);
    chk("R11 untouched", mem[8'hD0], 8'hD0);
    @(posedge clk); #1;
    chk("R11 idle", busy, 0);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_copy_up_single();
    t_copy_down_single();
    t_copy_repeat();
    t_search_hit();
    t_copy_keeps_z();
    t_search_miss();
    t_search_wrap();
    t_start_ignored();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule